// File: doc/BRIEF.md
# Two-Way Write-Back Set-Associative Cache

This block is a cache controller that sits between a processor request port and a slower word-wide memory port. Each word address is split into three fields. The low field picks a word inside a line. The middle field picks a set. The upper field is the tag, which is kept beside the line. Every set holds two lines. Each line carries a valid flag, a dirty flag, a tag and a full line of data words. Setting the way count to one turns the block into a direct-mapped cache.

Reads and writes that hit finish in the cycle they are presented. A miss stalls the processor while the controller works. If the chosen victim line is dirty, it is first written back to memory word by word. The requested line is then fetched in full, and the request is replayed as a hit. Writes are held in the cache (write-back). A write miss first allocates the line. A one-bit recency mark per set chooses the victim when both ways are valid. A flush command walks every line and writes back each dirty one.

Top module: `wb_cache2`

## Requirements
- R1: After reset no line is valid; `cpu_busy`, `cpu_done` and `mem_req` are low.
- R2: A read or write that hits raises `cpu_done` in the same cycle as `cpu_req`, with no memory traffic; for a read, `cpu_rdata` holds the addressed word.
- R3: With the default parameters the word address is split as offset = bits [1:0], set = bits [4:2] and tag = bits [11:5]. A read miss fetches all 4 words of the line from memory and then returns the addressed word. Each memory beat keeps its address and direction stable until `mem_ready`.
- R4: A write hit updates the cached word and marks the line dirty. It causes no memory traffic, and the memory copy stays old until the line is written back.
- R5: A write miss first loads the whole line from memory, then applies the write. Reads of the other words of that line return the memory contents.
- R6: When both ways of a set are valid, a miss replaces the way that was used less recently. Use means a hit or a fill.
- R7: A dirty victim is written to memory in full before the refill starts, so the first beat of such a miss is a write. A clean victim causes no write beats.
- R8: A miss in a set with an invalid way fills that way and evicts nothing.
- R9: A pulse on `flush` while idle writes back every valid dirty line and clears its dirty flag. Memory then matches the processor's view, and a second flush issues no writes.
- R10: From the cycle a miss or flush is accepted until it completes, `cpu_busy` is high and `cpu_done` stays low. The processor holds its request stable until `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Miss handling or flush in progress |
| flush | input | 1 | Start a write-back of all dirty lines |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat word address |
| mem_wdata | output | DATA_W | Beat write data |
| mem_rdata | input | DATA_W | Beat read data, valid with `mem_ready` |
| mem_ready | input | 1 | Beat completes this cycle |

## Verification
The bench builds the block with its defaults: two ways, eight sets, four-word lines and a 12-bit word address. It answers each memory beat after a fixed four-cycle latency. The address space is small enough that a behavioural memory image can be compared word for word after a flush. The directed section works in one set, which makes the cold fill, invalid-way preference, recency victim choice and dirty write-back order all visible from beat counts. A random phase confined to four tags over all sets then forces heavy conflict traffic.

// File: rtl/wb_cache2.sv
module wb_cache2 #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int SET_W  = 3,
  parameter int WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  input  logic              flush,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int WPL   = 1 << OFF_W;
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_FSCAN, S_FWB} st_t;
  st_t st;

  logic              valid [WAYS][SETS];
  logic              dirty [WAYS][SETS];
  logic [TAG_W-1:0]  tagm  [WAYS][SETS];
  logic [DATA_W-1:0] line  [WAYS][SETS][WPL];
  logic              lru   [SETS];

  logic [OFF_W-1:0] beat;
  logic             vway, fway;
  logic [SET_W-1:0] fset;

  wire [TAG_W-1:0] rtag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] rset = cpu_addr[OFF_W +: SET_W];
  wire [OFF_W-1:0] roff = cpu_addr[OFF_W-1:0];

  logic hit, hway, victim;
  always_comb begin
    hit  = 1'b0;
    hway = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (valid[w][rset] && tagm[w][rset] == rtag) begin
        hit  = 1'b1;
        hway = w[0];
      end
  end

  always_comb begin
    if (WAYS == 1)                   victim = 1'b0;
    else if (!valid[0][rset])        victim = 1'b0;
    else if (!valid[WAYS-1][rset])   victim = 1'b1;
    else                             victim = lru[rset];
  end

  wire idle      = (st == S_IDLE);
  wire beat_last = &beat;
  wire slot_last = (fset == SET_W'(SETS-1)) && (fway == 1'(WAYS-1));

  assign cpu_busy  = !idle;
  assign cpu_done  = idle && !flush && cpu_req && hit;
  assign cpu_rdata = line[hway][rset][roff];
  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_FWB);
  assign mem_we    = (st == S_WB) || (st == S_FWB);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_WB: begin
        mem_addr  = {tagm[vway][rset], rset, beat};
        mem_wdata = line[vway][rset][beat];
      end
      S_FILL: mem_addr = {rtag, rset, beat};
      S_FWB: begin
        mem_addr  = {tagm[fway][fset], fset, beat};
        mem_wdata = line[fway][fset][beat];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      beat <= '0;
      vway <= 1'b0;
      fway <= 1'b0;
      fset <= '0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          valid[w][s] <= 1'b0;
          dirty[w][s] <= 1'b0;
        end
      for (int s = 0; s < SETS; s++) lru[s] <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (flush) begin
            fset <= '0;
            fway <= 1'b0;
            st   <= S_FSCAN;
          end else if (cpu_req) begin
            if (hit) begin
              if (cpu_we) begin
                line[hway][rset][roff] <= cpu_wdata;
                dirty[hway][rset]      <= 1'b1;
              end
              lru[rset] <= ~hway;
            end else begin
              vway <= victim;
              beat <= '0;
              if (valid[victim][rset] && dirty[victim][rset]) st <= S_WB;
              else begin
                valid[victim][rset] <= 1'b0;
                st <= S_FILL;
              end
            end
          end
        S_WB:
          if (mem_ready) begin
            beat <= beat + 1'b1;
            if (beat_last) begin
              valid[vway][rset] <= 1'b0;
              dirty[vway][rset] <= 1'b0;
              st <= S_FILL;
            end
          end
        S_FILL:
          if (mem_ready) begin
            line[vway][rset][beat] <= mem_rdata;
            beat <= beat + 1'b1;
            if (beat_last) begin
              valid[vway][rset] <= 1'b1;
              dirty[vway][rset] <= 1'b0;
              tagm[vway][rset]  <= rtag;
              lru[rset]         <= ~vway;
              st <= S_IDLE;
            end
          end
        S_FSCAN:
          if (valid[fway][fset] && dirty[fway][fset]) begin
            beat <= '0;
            st   <= S_FWB;
          end else begin
            if (fway == 1'(WAYS-1)) begin
              fway <= 1'b0;
              fset <= fset + 1'b1;
            end else fway <= 1'b1;
            if (slot_last) st <= S_IDLE;
          end
        S_FWB:
          if (mem_ready) begin
            beat <= beat + 1'b1;
            if (beat_last) begin
              dirty[fway][fset] <= 1'b0;
              if (fway == 1'(WAYS-1)) begin
                fway <= 1'b0;
                fset <= fset + 1'b1;
              end else fway <= 1'b1;
              st <= slot_last ? S_IDLE : S_FSCAN;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_cache2_chk.sv
module wb_cache2_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              cpu_busy,
  input logic              flush,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready
);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_busy);

  p_mem_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_busy);

  p_miss_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy && !cpu_done) |=> cpu_busy);

  p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_flush_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !cpu_busy) |=> cpu_busy);
endmodule

bind wb_cache2 wb_cache2_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
  .cpu_busy(cpu_busy), .flush(flush), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/wb_cache2_tb.sv
module wb_cache2_tb;
  localparam int AW = 12, DW = 32, LAT = 4, MSZ = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, flush = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
  logic cpu_done, cpu_busy, mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  wb_cache2 u_dut (.*);

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] refm [MSZ];
  int rd_beats, wr_beats, lat_cnt, checks, fails;
  bit first_we;

  function automatic logic [DW-1:0] init_val(int a);
    return (DW'(a) * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction
  function automatic int mk(int t, int s, int o);
    return (t << 5) | (s << 2) | o;
  endfunction

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  initial begin
    mem_ready = 0; mem_rdata = '0; lat_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ready) begin
        lat_cnt++;
        if (lat_cnt == LAT) begin
          lat_cnt = 0;
          mem_ready = 1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata; wr_beats++;
            if (rd_beats + wr_beats == 1) first_we = 1;
          end else begin
            mem_rdata = mem[mem_addr]; rd_beats++;
            if (rd_beats + wr_beats == 1) first_we = 0;
          end
        end
      end else mem_ready = 0;
    end
  end

  int cyc; bit saw_busy; logic [DW-1:0] rdv;

  task automatic access(input bit we, input int a, input logic [DW-1:0] wd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
    rd_beats = 0; wr_beats = 0; cyc = 0; saw_busy = 0;
    forever begin
      #1;
      if (cpu_done) begin rdv = cpu_rdata; break; end
      if (cpu_busy) saw_busy = 1;
      @(negedge clk); cyc++;
    end
    if (we) refm[a] = wd;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    rd_beats = 0; wr_beats = 0;
    flush = 1;
    @(negedge clk);
    flush = 0;
    #1;
    while (cpu_busy) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MSZ; i++) begin mem[i] = init_val(i); refm[i] = init_val(i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 busy", 32'(cpu_busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 done", 32'(cpu_done), 0);

    access(0, mk(1,2,1), 0);
    chk("R3 data", rdv, init_val(mk(1,2,1)));
    chk("R3 line beats", rd_beats, 4);
    chk("R10 busy seen", 32'(saw_busy), 1);
    access(0, mk(1,2,3), 0);
    chk("R2 hit cycles", cyc, 0);
    chk("R2 hit data", rdv, init_val(mk(1,2,3)));
    chk("R2 no traffic", rd_beats + wr_beats, 0);

    access(1, mk(1,2,0), 32'hCAFE_0001);
    chk("R4 write hit cycles", cyc, 0);
    chk("R4 no traffic", rd_beats + wr_beats, 0);
    chk("R4 memory unchanged", mem[mk(1,2,0)], init_val(mk(1,2,0)));
    access(0, mk(1,2,0), 0);
    chk("R4 readback", rdv, 32'hCAFE_0001);

    access(0, mk(2,2,0), 0);
    chk("R8 no writeback", wr_beats, 0);
    access(0, mk(1,2,0), 0);
    chk("R8 first line kept", cyc, 0);

    access(0, mk(3,2,0), 0);
    chk("R7 clean victim no writes", wr_beats, 0);
    access(0, mk(1,2,2), 0);
    chk("R6 recent line kept", cyc, 0);
    access(0, mk(2,2,0), 0);
    chk("R6 older line evicted", rd_beats, 4);
    chk("R6 data", rdv, init_val(mk(2,2,0)));

    access(0, mk(3,2,1), 0);
    chk("R7 dirty writeback beats", wr_beats, 4);
    chk("R7 write first", 32'(first_we), 1);
    chk("R7 memory updated", mem[mk(1,2,0)], 32'hCAFE_0001);
    chk("R7 refill data", rdv, init_val(mk(3,2,1)));

    access(1, mk(5,4,2), 32'hBEEF_0002);
    chk("R5 allocate beats", rd_beats, 4);
    access(0, mk(5,4,2), 0);
    chk("R5 readback", rdv, 32'hBEEF_0002);
    access(0, mk(5,4,1), 0);
    chk("R5 neighbour", rdv, init_val(mk(5,4,1)));

    do_flush();
    chk("R9 flush writes", wr_beats, 4);
    chk("R9 flushed value", mem[mk(5,4,2)], 32'hBEEF_0002);
    do_flush();
    chk("R9 second flush idle", wr_beats, 0);

    for (int n = 0; n < 400; n++) begin
      int a; bit w; logic [DW-1:0] d;
      a = mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3));
      w = $urandom_range(0,1) == 1;
      d = $urandom;
      access(w, a, d);
      if (!w) chk("R3 random read", rdv, refm[a]);
    end
    do_flush();
    begin
      int mism = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== refm[i]) mism++;
      chk("R9 memory image", mism, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule